// File: doc/BRIEF.md
# LED Fade Ramp Controller

This block drives the brightness code of one group of white LEDs. A host writes a 6-bit target code and a 2-bit fade choice. The block then moves its applied code toward that target, one code step at a time. Each step is held for a dwell time of 8, 16 or 32 milliseconds. The dwell is counted on an external millisecond tick, so the block runs from any system clock.

Code n stands for (n+1)/64 of the full-scale current. Code 63 is therefore full scale, and code 0 is the dimmest lit level. Turning the group on fades up from code 0, and turning it off fades down to code 0. An active flag marks whether the group is lit at all. The flag drops only once the ramp down has finished, so "off" stays distinct from "lowest step".

A product with a main group and a separate sub group uses two instances. Each instance has its own target and its own fade choice.

Top module: `fade_ramp_ctrl`

## Requirements
- R1: While reset is asserted, and after its release with the group disabled, the applied code is 0 and both the active and busy flags are low.
- R2: With a fade choice other than 00, the applied code changes by at most one step per clock.
- R3: Fade choices select the dwell on the tick input: 01 gives 8 ticks, 10 gives 16 ticks and 11 gives 32 ticks. After a ramp starts from rest, the k-th counted tick leaves the code moved by floor(k/dwell) steps, and never past the target.
- R4: With fade choice 00, the applied code equals the effective target on the next clock.
- R5: In fade modes the code rises while below the effective target and falls while above it, and it never overshoots.
- R6: A new target written during a ramp does not restart the dwell count. The next step comes at the time it would have come had the target not changed, and it heads toward the new target.
- R7: The effective target is the written target while the group is enabled, and 0 while it is disabled. Enabling sets the active flag on the next clock. After a disable, the active flag clears on the clock after the code has reached 0.
- R8: The busy flag is high exactly when the applied code differs from the effective target.
- R9: In fade modes, a clock without a tick leaves the applied code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| grp_en | input | 1 | Group on (1) or off (0) |
| target_code | input | 6 | Requested brightness code |
| fade_sel | input | 2 | 00 immediate, 01/10/11 dwell of 8/16/32 ticks |
| level_code | output | 6 | Applied brightness code |
| grp_active | output | 1 | Group lit |
| ramp_busy | output | 1 | Applied code differs from effective target |

## Verification
The hardest case to reach from the ports is a target change that lands part-way through a dwell. Only the timing of the following step shows whether the hidden tick count survived the change. The bench holds the tick high on every clock, so that dwell counts equal clock counts. It then rewrites the target at a known offset inside a dwell, both upward and downward, and checks the exact clock of the next step. A second subtle case is the one-clock lag of the active flag behind the code reaching 0. Full up and down ramps for every fade choice pin that lag down.

// File: rtl/fade_ramp_pkg.sv
package fade_ramp_pkg;
   typedef enum logic [1:0] {
      FADE_NONE = 2'b00,
      FADE_X1   = 2'b01,
      FADE_X2   = 2'b10,
      FADE_X4   = 2'b11
   } fade_sel_e;

   // dwell in ticks for a fade choice, given the base dwell of choice 01
   function automatic int unsigned dwell_ticks(input int unsigned sel, input int unsigned base);
      if (sel == 0) return 0;
      return base << (sel - 1);
   endfunction
endpackage

// File: rtl/fade_dwell_timer.sv
module fade_dwell_timer
   import fade_ramp_pkg::*;
#(
   parameter int unsigned BASE_DWELL = 8,
   parameter int unsigned SEL_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             step_fire
);
   localparam int unsigned NSEL    = 1 << SEL_W;
   localparam int unsigned MAX_DW  = dwell_ticks(NSEL - 1, BASE_DWELL);
   localparam int unsigned LIM_W   = $clog2(MAX_DW + 1);

   logic [LIM_W-1:0] lim_m1 [NSEL];
   logic [LIM_W-1:0] cnt_q;

   assign lim_m1[0] = '0;
   for (genvar g = 1; g < NSEL; g++) begin : g_lim
      assign lim_m1[g] = LIM_W'(dwell_ticks(g, BASE_DWELL) - 1);
   end

   assign step_fire = run && ms_tick && (cnt_q >= lim_m1[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run)      cnt_q <= '0;
      else if (ms_tick)   cnt_q <= step_fire ? '0 : cnt_q + LIM_W'(1);
   end

   // the tick count stays below the longest dwell (R3)
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_W'(MAX_DW - 1));
   // an idle timer holds no partial dwell (R3)
   assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);
endmodule

// File: rtl/fade_level_reg.sv
module fade_level_reg #(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_now,
   input  logic              step_fire,
   input  logic [CODE_W-1:0] goal,
   output logic [CODE_W-1:0] level
);
   logic [CODE_W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 level_q <= '0;
      else if (load_now)          level_q <= goal;
      else if (step_fire) begin
         if (level_q < goal)      level_q <= level_q + CODE_W'(1);
         else if (level_q > goal) level_q <= level_q - CODE_W'(1);
      end
   end

   assign level = level_q;

   // a step never crosses the goal (R5)
   assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_now && level_q < goal) |=> level_q <= $past(goal));
   assert_no_undershoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_now && level_q > goal) |=> level_q >= $past(goal));
endmodule

// File: rtl/fade_group_flag.sv
module fade_group_flag #(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_en,
   input  logic [CODE_W-1:0] level,
   output logic              active
);
   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= grp_en || (active_q && (level != '0));
   end

   assign active = active_q;

   assert_on_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en |=> active_q);
   assert_off_after_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_en && level == '0) |=> !active_q);
endmodule

// File: rtl/fade_ramp_ctrl.sv
module fade_ramp_ctrl
   import fade_ramp_pkg::*;
#(
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned BASE_DWELL = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              grp_en,
   input  logic [CODE_W-1:0] target_code,
   input  logic [SEL_W-1:0]  fade_sel,
   output logic [CODE_W-1:0] level_code,
   output logic              grp_active,
   output logic              ramp_busy
);
   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("SEL_W must be 1 to 3");
   end
   if (BASE_DWELL < 1) begin : g_bad_dwell
      $error("BASE_DWELL must be at least 1");
   end

   logic [CODE_W-1:0] eff_goal;
   logic              fading;
   logic              step_fire;

   assign eff_goal  = grp_en ? target_code : '0;
   assign fading    = (fade_sel != '0);
   assign ramp_busy = (level_code != eff_goal);

   fade_dwell_timer #(.BASE_DWELL(BASE_DWELL), .SEL_W(SEL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .run(ramp_busy && fading), .sel(fade_sel), .step_fire(step_fire));

   fade_level_reg #(.CODE_W(CODE_W)) u_level (
      .clk(clk), .rst_n(rst_n), .load_now(!fading), .step_fire(step_fire),
      .goal(eff_goal), .level(level_code));

   fade_group_flag #(.CODE_W(CODE_W)) u_flag (
      .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .level(level_code),
      .active(grp_active));

   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fading |=> (level_code == $past(level_code)) ||
                 (level_code == $past(level_code) + CODE_W'(1)) ||
                 (level_code == $past(level_code) - CODE_W'(1)));
   assert_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fading |=> level_code == $past(grp_en ? target_code : '0));
   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fading && !ms_tick) |=> $stable(level_code));
endmodule

// File: tb/tb_fade_ramp_ctrl.sv
`timescale 1ns/1ps
module tb_fade_ramp_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       grp_en = 1'b0;
   logic [5:0] target_code = '0;
   logic [1:0] fade_sel = 2'b00;
   logic [5:0] level_code;
   logic       grp_active;
   logic       ramp_busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fade_ramp_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .grp_en(grp_en),
      .target_code(target_code), .fade_sel(fade_sel),
      .level_code(level_code), .grp_active(grp_active), .ramp_busy(ramp_busy));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic settle_off();
      grp_en = 1'b0; fade_sel = 2'b00; ms_tick = 1'b1;
      cyc(3);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cyc(3);
      chk("R1 code in reset", level_code, 0);
      chk("R1 active in reset", grp_active, 0);
      chk("R1 busy in reset", ramp_busy, 0);
      rst_n = 1'b1;
      target_code = 6'd20;
      cyc(3);
      chk("R1 code after reset", level_code, 0);
      chk("R1 active after reset", grp_active, 0);
      chk("R8 busy off with disabled group", ramp_busy, 0);

      // R3 R5 R7 R8 sweep over fade choices and targets, tick every clock
      ms_tick = 1'b1;
      for (int fs = 1; fs < 4; fs++) begin
         for (int ti = 0; ti < 3; ti++) begin
            int d;
            int tgt;
            d = 8 << (fs - 1);
            tgt = (ti == 0) ? 1 : (ti == 1) ? 7 : 63;
            settle_off();
            fade_sel = 2'(fs); target_code = 6'(tgt); grp_en = 1'b1;
            for (int k = 1; k <= tgt * d + 2; k++) begin
               int e;
               cyc(1);
               e = imin(tgt, k / d);
               chk("R3 ramp up code", level_code, e);
               chk("R7 active during fade in", grp_active, 1);
               chk("R8 busy during fade in", ramp_busy, (e != tgt) ? 1 : 0);
            end
            grp_en = 1'b0;
            for (int k = 1; k <= tgt * d + 2; k++) begin
               int e;
               cyc(1);
               e = tgt - imin(tgt, k / d);
               chk("R5 ramp down code", level_code, e);
               chk("R7 active during fade out", grp_active, (k <= tgt * d) ? 1 : 0);
               chk("R8 busy during fade out", ramp_busy, (e != 0) ? 1 : 0);
            end
         end
      end

      // R4 immediate mode
      settle_off();
      grp_en = 1'b1; target_code = 6'd37; fade_sel = 2'b00;
      cyc(1);
      chk("R4 immediate load", level_code, 37);
      chk("R8 busy after immediate", ramp_busy, 0);
      target_code = 6'd5;
      cyc(1);
      chk("R4 immediate reload", level_code, 5);
      grp_en = 1'b0;
      cyc(1);
      chk("R4 immediate off code", level_code, 0);
      chk("R7 active lag after zero", grp_active, 1);
      cyc(1);
      chk("R7 active cleared", grp_active, 0);

      // R6 retarget mid dwell, upward then downward
      settle_off();
      fade_sel = 2'b01; grp_en = 1'b1; target_code = 6'd40;
      cyc(20);
      chk("R6 code before retarget", level_code, 2);
      target_code = 6'd10;
      cyc(3);
      chk("R6 no early step", level_code, 2);
      cyc(1);
      chk("R6 step keeps dwell phase", level_code, 3);
      cyc(4);
      target_code = 6'd1;
      cyc(3);
      chk("R6 down no early step", level_code, 3);
      cyc(1);
      chk("R6 down step keeps phase", level_code, 2);
      cyc(8);
      chk("R5 down to new target", level_code, 1);
      chk("R8 busy clear at target", ramp_busy, 0);

      // R9 no tick holds the code, R2 single step when ticks resume
      settle_off();
      fade_sel = 2'b01; grp_en = 1'b1; target_code = 6'd30;
      cyc(16);
      chk("R3 two steps", level_code, 2);
      ms_tick = 1'b0;
      cyc(25);
      chk("R9 hold without tick", level_code, 2);
      chk("R8 busy while held", ramp_busy, 1);
      ms_tick = 1'b1;
      cyc(8);
      chk("R2 one step after resume", level_code, 3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule